// File: doc/BRIEF.md
# Host Watchdog Timer

This block watches a host that manages the chip over a serial management bus. It forces a reset if the host stops talking. The bus engine gives a one-cycle strobe for each completed transaction, and a slow tick supplies the time base. The block stays idle until the first strobe after reset. From then on it counts ticks, and every strobe sets the count back to zero. If the count reaches the selected timeout, the block pulses one of two reset requests.

A 2-bit mode code sets both the timeout length and the reset severity:

| Code | Timeout | Reset requested |
|------|---------|-----------------|
| 00 | `LONG_TICKS` | soft reset of the read/write registers |
| 01 | `LONG_TICKS` | hard reset |
| 10 | `SHORT_TICKS` | hard reset |
| 11 | none | watchdog off |

A separate disable input also switches the watchdog off, whatever the code. After it fires, or after it has been switched off, the watchdog waits for a new transaction before it counts again.

The timeouts are parameters in tick units. With a 1 s tick, the defaults of 160 and 40 give the intended durations. No data stream passes through the block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `host_wdog`

## Requirements
- R1: After reset both reset outputs are low and the watchdog is idle. Ticks that arrive before the first transaction strobe cause no pulse.
- R2: A transaction strobe while the watchdog is enabled arms it and clears the count. A tick in the same cycle as a strobe is not counted.
- R3: With code 00, the LONG_TICKS-th tick after the last strobe produces a soft-reset pulse and no hard-reset pulse. The pulse is visible in the cycle after the edge that samples that tick.
- R4: With code 01, the LONG_TICKS-th tick after the last strobe produces a hard-reset pulse and no soft-reset pulse.
- R5: With code 10, the SHORT_TICKS-th tick after the last strobe produces a hard-reset pulse. The count never reaches the active limit.
- R6: Code 11 turns the watchdog off. No pulse is produced, strobes are ignored, and arming is cleared, so a new strobe is needed after a counting code returns.
- R7: When the disable input is high, the watchdog is off under every code, with the same effects as in R6.
- R8: Each reset pulse lasts one cycle. The two reset outputs are never high together.
- R9: After it fires, the watchdog is idle. Further ticks produce no pulse until the next strobe.
- R10: A change of the mode code while armed restarts the count from zero under the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| txn_done_i | input | 1 | One-cycle strobe per completed host transaction |
| mode_sel_i | input | 2 | Timeout/severity code (00 soft long, 01 hard long, 10 hard short, 11 off) |
| wdog_off_i | input | 1 | High switches the watchdog off |
| tick_i | input | 1 | One-cycle time-base tick |
| soft_rst_o | output | 1 | One-cycle request to restore the read/write registers to their defaults |
| hard_rst_o | output | 1 | One-cycle hard-reset request |

## Verification
The assertions assume that `mode_sel_i` and `wdog_off_i` are synchronous to the clock and settle before each edge. They also assume that a mode change is detected against the code registered in the previous cycle, so the count-bound check is relaxed in the cycle a new code appears.

The bench drives every input on the falling edge and holds a mode change for at least one cycle before the next strobe. Ticks and strobes are always one cycle wide. Outputs are sampled on the falling edge after the edge that sampled the deciding tick.

// File: rtl/hwd_pkg.sv
package hwd_pkg;
  typedef enum logic [1:0] {
    HWD_SOFT_LONG  = 2'b00,
    HWD_HARD_LONG  = 2'b01,
    HWD_HARD_SHORT = 2'b10,
    HWD_OFF        = 2'b11
  } hwd_mode_e;
endpackage

// File: rtl/hwd_mode_decode.sv
module hwd_mode_decode
  import hwd_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 160,
  parameter int unsigned SHORT_TICKS = 40,
  parameter int unsigned CNT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_sel_i,
  input  logic             wdog_off_i,
  output logic             enable_o,
  output logic             hard_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             mode_chg_o
);
  hwd_mode_e  mode;
  logic [1:0] mode_q;

  // Track the previous code so that a change restarts the count.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= 2'b00;
    else         mode_q <= mode_sel_i;
  end

  assign mode_chg_o = (mode_sel_i != mode_q);

  always_comb begin
    mode     = hwd_mode_e'(mode_sel_i);
    enable_o = !wdog_off_i;
    hard_o   = 1'b0;
    limit_o  = CNT_W'(LONG_TICKS);
    case (mode)
      HWD_SOFT_LONG:  begin hard_o = 1'b0; limit_o = CNT_W'(LONG_TICKS);  end
      HWD_HARD_LONG:  begin hard_o = 1'b1; limit_o = CNT_W'(LONG_TICKS);  end
      HWD_HARD_SHORT: begin hard_o = 1'b1; limit_o = CNT_W'(SHORT_TICKS); end
      default:        enable_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hwd_timeout_ctr.sv
module hwd_timeout_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             restart_i,
  input  logic             mode_chg_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             armed_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;
  logic             last_tick;

  assign last_tick = (count_q == limit_i - CNT_W'(1));
  assign expire_o  = enable_i && armed_o && tick_i && !restart_i && !mode_chg_i && last_tick;

  // Priority: off, then strobe, then code change, then tick.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      count_q <= '0;
    end else if (!enable_i) begin
      armed_o <= 1'b0;
      count_q <= '0;
    end else if (restart_i) begin
      armed_o <= 1'b1;
      count_q <= '0;
    end else if (mode_chg_i) begin
      count_q <= '0;
    end else if (armed_o && tick_i) begin
      if (last_tick) begin
        armed_o <= 1'b0;
        count_q <= '0;
      end else begin
        count_q <= count_q + CNT_W'(1);
      end
    end
  end

  assert_off_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!armed_o && count_q == '0));
  assert_strobe_arms_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && restart_i) |=> (armed_o && count_q == '0));
  assert_mode_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && mode_chg_i && !restart_i) |=> (count_q == '0));
  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !mode_chg_i) |-> (count_q < limit_i));
  assert_fire_disarms_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !armed_o);
endmodule

// File: rtl/hwd_pulse_gen.sv
module hwd_pulse_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic hard_i,
  output logic soft_o,
  output logic hard_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      soft_o <= 1'b0;
      hard_o <= 1'b0;
    end else begin
      soft_o <= fire_i && !hard_i;
      hard_o <= fire_i && hard_i;
    end
  end

  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(soft_o && hard_o));
  assert_soft_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_o |=> !soft_o);
  assert_hard_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_o |=> !hard_o);
endmodule

// File: rtl/host_wdog.sv
module host_wdog #(
  parameter int unsigned LONG_TICKS  = 160,
  parameter int unsigned SHORT_TICKS = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       txn_done_i,
  input  logic [1:0] mode_sel_i,
  input  logic       wdog_off_i,
  input  logic       tick_i,
  output logic       soft_rst_o,
  output logic       hard_rst_o
);
  localparam int unsigned CNT_W = $clog2(LONG_TICKS + 1);

  logic             enable;
  logic             hard_sel;
  logic             mode_chg;
  logic             armed;
  logic             expire;
  logic [CNT_W-1:0] limit;

  hwd_mode_decode #(
    .LONG_TICKS (LONG_TICKS),
    .SHORT_TICKS(SHORT_TICKS),
    .CNT_W      (CNT_W)
  ) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_sel_i(mode_sel_i),
    .wdog_off_i(wdog_off_i),
    .enable_o  (enable),
    .hard_o    (hard_sel),
    .limit_o   (limit),
    .mode_chg_o(mode_chg)
  );

  hwd_timeout_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable),
    .restart_i (txn_done_i),
    .mode_chg_i(mode_chg),
    .tick_i    (tick_i),
    .limit_i   (limit),
    .armed_o   (armed),
    .expire_o  (expire)
  );

  hwd_pulse_gen u_pulse (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(expire),
    .hard_i(hard_sel),
    .soft_o(soft_rst_o),
    .hard_o(hard_rst_o)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !txn_done_i) |=> (!soft_rst_o && !hard_rst_o));
  assert_off_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_off_i |=> (!soft_rst_o && !hard_rst_o));
endmodule

// File: tb/tb_host_wdog.sv
module tb_host_wdog;
  localparam int LONG  = 160;
  localparam int SHORT = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       txn;
  logic [1:0] mode;
  logic       off;
  logic       tick;
  logic       sw;
  logic       hw;
  int         n_chk  = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  host_wdog #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .txn_done_i(txn), .mode_sel_i(mode),
    .wdog_off_i(off), .tick_i(tick), .soft_rst_o(sw), .hard_rst_o(hw)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {soft,hard} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic s);
    tick = t; txn = s;
    @(posedge clk); @(negedge clk);
    tick = 1'b0; txn = 1'b0;
  endtask

  task automatic run_ticks(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0);
      if (sw || hw) pulses++;
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode = m;
    step(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    int p;
    check("R1 reset state", {sw, hw}, 2'b00);
    run_ticks(LONG + 20, p);
    check("R1 no count before first strobe", {1'b0, p != 0}, 2'b00);
  endtask

  task automatic t_timeout(input logic [1:0] m, input int n, input logic [1:0] exp, input string req);
    int p;
    set_mode(m);
    step(1'b0, 1'b1);
    run_ticks(n - 1, p);
    check({req, " quiet before limit"}, {1'b0, p != 0}, 2'b00);
    step(1'b1, 1'b0);
    check({req, " pulse at limit"}, {sw, hw}, exp);
    step(1'b0, 1'b0);
    check("R8 pulse one cycle", {sw, hw}, 2'b00);
    run_ticks(LONG + 5, p);
    check("R9 idle after firing", {1'b0, p != 0}, 2'b00);
  endtask

  task automatic t_restart();
    int p;
    set_mode(2'b10);
    step(1'b0, 1'b1);
    run_ticks(SHORT - 10, p);
    step(1'b0, 1'b1);
    run_ticks(SHORT - 1, p);
    check("R2 strobe restarts count", {1'b0, p != 0}, 2'b00);
    step(1'b1, 1'b0);
    check("R2 fire after restart", {sw, hw}, 2'b01);
    step(1'b1, 1'b1);
    run_ticks(SHORT - 1, p);
    check("R2 tick with strobe not counted", {1'b0, p != 0}, 2'b00);
    step(1'b1, 1'b0);
    check("R2 fire after strobe+tick", {sw, hw}, 2'b01);
  endtask

  task automatic t_mode_off();
    int p;
    set_mode(2'b10);
    step(1'b0, 1'b1);
    run_ticks(20, p);
    set_mode(2'b11);
    step(1'b0, 1'b1);
    run_ticks(LONG, p);
    check("R6 code 11 silent", {1'b0, p != 0}, 2'b00);
    set_mode(2'b10);
    run_ticks(SHORT + 10, p);
    check("R6 needs new strobe after off", {1'b0, p != 0}, 2'b00);
    step(1'b0, 1'b1);
    run_ticks(SHORT, p);
    check("R6 counts again after strobe", {1'b0, p == 1}, 2'b01);
  endtask

  task automatic t_disable();
    int p;
    set_mode(2'b01);
    step(1'b0, 1'b1);
    run_ticks(10, p);
    off = 1'b1;
    step(1'b0, 1'b1);
    run_ticks(LONG + 10, p);
    check("R7 disable bit silent", {1'b0, p != 0}, 2'b00);
    off = 1'b0;
    run_ticks(LONG + 10, p);
    check("R7 needs new strobe after disable", {1'b0, p != 0}, 2'b00);
    step(1'b0, 1'b1);
    run_ticks(LONG - 1, p);
    step(1'b1, 1'b0);
    check("R7 fires after re-enable", {sw, hw}, 2'b01);
  endtask

  task automatic t_mode_change();
    int p;
    set_mode(2'b00);
    step(1'b0, 1'b1);
    run_ticks(100, p);
    set_mode(2'b01);
    run_ticks(LONG - 1, p);
    check("R10 code change restarts count", {1'b0, p != 0}, 2'b00);
    step(1'b1, 1'b0);
    check("R10 new code applies", {sw, hw}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; txn = 1'b0; mode = 2'b00; off = 1'b0; tick = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timeout(2'b00, LONG, 2'b10, "R3");
    t_timeout(2'b01, LONG, 2'b01, "R4");
    t_timeout(2'b10, SHORT, 2'b01, "R5");
    t_restart();
    t_mode_off();
    t_disable();
    t_mode_change();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule